// File: doc/BRIEF.md
# Color-Steered Scanner Front-End Control Registers

This block is the control register bank of a three-color image-sensor front end. A host reaches it over an 8-bit parallel bus with an active-low select, an active-low read strobe, an active-low write strobe and a 3-bit register address. The offset and gain settings exist once per color, but they are not given separate addresses. A 2-bit color pointer, held in the top two bits of the pointer register, decides which color's copy a data write reaches or a data read returns.

A second register, the mode register, holds the sampling-mode and converter-span controls and the clamp mode. The block also produces the input-clamp switch control. It combines the clamp mode with the sampling reset clock and the start-of-line flag. In single-channel mode the block exports the channel to digitize, which is the color the pointer held when the mode register was last written. All bus inputs are taken as synchronous to `clk`.

Top module: `color_steered_ctrl_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears to zero. This means pointer red, line clamp, color mode, all offsets, gains and mode bits 0, and the single-channel selection 0.
- R2: A write is captured at the first clock edge that sees `bus_wr_n` high after it was sampled low, provided `bus_cs_n` is low at that edge. A strobe pulse while `bus_cs_n` is high changes nothing.
- R3: Address 0 is the pointer register. Bits 7:6 are the pointer, with 00 = red, 01 = green and 10 = blue. Bits 5:0 read as 0.
- R4: A write to address 2 stores all 8 bits into the offset of the color the pointer selects at that moment. The other colors keep their values. `offset_all[8*c+7:8*c]` presents color c (0 red, 1 green, 2 blue).
- R5: A write to address 3 stores bits 3:0 into the gain of the selected color. Bits 7:4 are not stored and read as 0. `gain_all[4*c+3:4*c]` presents color c.
- R6: While the pointer holds 11, writes to addresses 2 and 3 leave every offset and gain unchanged, and reads of addresses 2 and 3 return 0.
- R7: Address 1 is the mode register. Bit 0 drives `cds_en`, bit 1 `mono_en`, bit 2 `span_4v`, bit 3 `span_2v` and bit 4 `span_ext`. Bit 5 is not stored and reads as 0. Bits 7:6 hold the clamp mode.
- R8: The clamp mode sets `clamp_sw`. With 00 (line), it equals `samp_rst_clk` while `line_start` is low and is 0 while `line_start` is high. With 01 (pixel), it equals `samp_rst_clk`. With 10 (none) and with 11, it is 0.
- R9: `mono_ch` takes the pointer value at each write to the mode register. It does not change when the pointer is changed later.
- R10: The block drives `bus_data` only while both `bus_cs_n` and `bus_rd_n` are low. At all other times it is high-impedance. Addresses 4 to 7 read as 0.
- R11: Reads of addresses 2 and 3 return the selected color's stored offset or gain. Reads of addresses 0 and 1 return the stored register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Bus select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 3 | Register address |
| bus_data | inout | 8 | Bidirectional data bus |
| samp_rst_clk | input | 1 | Sampling reset clock |
| line_start | input | 1 | Start-of-line flag, high at line start |
| clamp_sw | output | 1 | Input clamp switch closed when high |
| cds_en | output | 1 | Correlated double sampling enable |
| mono_en | output | 1 | Single-channel mode |
| span_4v | output | 1 | Wide converter span select |
| span_2v | output | 1 | Narrow converter span select |
| span_ext | output | 1 | External-reference span select |
| mono_ch | output | 2 | Channel used in single-channel mode |
| offset_all | output | 24 | Per-color offsets, red in the low byte |
| gain_all | output | 12 | Per-color gain codes, red in the low nibble |

## Verification
The riskiest corner is write steering. The bench moves the pointer between colors and checks that only the selected copy changes. A bank that decoded the pointer wrongly would corrupt a neighbour, and one that let code 11 through would overwrite blue or red. The bench also changes the pointer after a mode write to catch a `mono_ch` that follows the live pointer instead of the latched one. It raises `line_start` in line mode, where a wrong gate would keep the clamp closed at the start of a line. It drives its own pattern onto the bus with the select high, so a read path that ignored the select would corrupt the pattern.

// File: rtl/csr_pkg.sv
// Package: shared widths, register addresses and the clamp-mode type
// for the color-steered control register bank.
package csr_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int NUM_COLORS = 3;
    localparam int PTR_W      = 2;

    localparam logic [ADDR_W-1:0] ADR_POINTER = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MODE    = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_OFFSET  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_GAIN    = 3'd3;

    typedef enum logic [1:0] {
        CLAMP_LINE  = 2'b00,
        CLAMP_PIXEL = 2'b01,
        CLAMP_NONE  = 2'b10,
        CLAMP_RSVD  = 2'b11
    } clamp_mode_e;
endpackage

// File: rtl/csr_bus_port.sv
// Module: csr_bus_port
// Turns the active-low host strobes into a one-cycle write pulse and a
// read drive enable. Assumes the strobes are synchronous to clk.
module csr_bus_port (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_pulse,
    output logic rd_drive
);
    logic wr_n_q;

    // Remember the previous write-strobe level to spot its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_q <= 1'b1;
        else        wr_n_q <= wr_n;
    end

    // Write fires on the low-to-high strobe transition with select held low.
    assign wr_pulse = !wr_n_q && wr_n && !cs_n;
    // Bus is driven only while select and read strobe are both low.
    assign rd_drive = !cs_n && !rd_n;

    assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
    assert_wr_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> (!cs_n && $rose(wr_n)));
endmodule

// File: rtl/csr_color_bank.sv
// Module: csr_color_bank
// One storage word per color, written only at the color given by sel.
// A sel at or beyond NUM_COLORS (the reserved code) blocks the write
// and reads back zero.
module csr_color_bank #(
    parameter int NUM_COLORS = 3,
    parameter int WIDTH      = 8,
    parameter int SEL_W      = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            sel,
    input  logic [WIDTH-1:0]            wdata,
    output logic [NUM_COLORS*WIDTH-1:0] words,
    output logic [WIDTH-1:0]            rd_word
);
    for (genvar c = 0; c < NUM_COLORS; c++) begin : g_color
        // Hold one color's word; load it when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[c*WIDTH +: WIDTH] <= '0;
            else if (wr_en && (int'(sel) == c))
                words[c*WIDTH +: WIDTH] <= wdata;
        end
    end

    // Return the selected color's word, or zero for a reserved selection.
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_COLORS; c++)
            if (int'(sel) == c) rd_word = words[c*WIDTH +: WIDTH];
    end

    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words));
    assert_bank_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(sel) >= NUM_COLORS)) |=> $stable(words));
endmodule

// File: rtl/csr_clamp_gate.sv
// Module: csr_clamp_gate
// Derives the input-clamp switch from the clamp mode, the sampling reset
// clock and the start-of-line flag. Purely combinational.
module csr_clamp_gate
    import csr_pkg::*;
(
    input  clamp_mode_e mode,
    input  logic        rst_clk,
    input  logic        line_start,
    output logic        sw
);
    // Select the switch behaviour for each clamp mode.
    always_comb begin
        unique case (mode)
            CLAMP_LINE:  sw = rst_clk && !line_start;
            CLAMP_PIXEL: sw = rst_clk;
            default:     sw = 1'b0;
        endcase
    end
endmodule

// File: rtl/color_steered_ctrl_regs.sv
// Module: color_steered_ctrl_regs
// Control register bank whose per-color offset and gain words are
// reached through a color pointer. Holds the mode register, latches the
// single-channel selection, and gates the input clamp switch.
// Assumes all bus inputs are synchronous to clk.
module color_steered_ctrl_regs
    import csr_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int GAIN_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_cs_n,
    input  logic                         bus_rd_n,
    input  logic                         bus_wr_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    inout  wire  [DATA_W-1:0]            bus_data,
    input  logic                         samp_rst_clk,
    input  logic                         line_start,
    output logic                         clamp_sw,
    output logic                         cds_en,
    output logic                         mono_en,
    output logic                         span_4v,
    output logic                         span_2v,
    output logic                         span_ext,
    output logic [PTR_W-1:0]             mono_ch,
    output logic [NUM_COLORS*OFS_W-1:0]  offset_all,
    output logic [NUM_COLORS*GAIN_W-1:0] gain_all
);
    localparam int GAIN_PAD = DATA_W - GAIN_W;
    localparam int PTR_LSB  = DATA_W - PTR_W;

    logic              wr_pulse, rd_drive;
    logic [DATA_W-1:0] wdata, rd_data;
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] mode_q;
    logic [OFS_W-1:0]  ofs_rd;
    logic [GAIN_W-1:0] gain_rd;
    logic              wr_ptr, wr_mode, wr_ofs, wr_gain;
    clamp_mode_e       clamp_mode;

    assign wdata = bus_data;

    csr_bus_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (bus_cs_n),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .wr_pulse (wr_pulse),
        .rd_drive (rd_drive)
    );

    // Decode the write target from the address.
    assign wr_ptr  = wr_pulse && (bus_addr == ADR_POINTER);
    assign wr_mode = wr_pulse && (bus_addr == ADR_MODE);
    assign wr_ofs  = wr_pulse && (bus_addr == ADR_OFFSET);
    assign wr_gain = wr_pulse && (bus_addr == ADR_GAIN);

    // Color pointer held in the top bits of the pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (wr_ptr) ptr_q <= wdata[DATA_W-1:PTR_LSB];
    end

    // Mode register; the must-be-zero bit 5 is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= {wdata[7:6], 1'b0, wdata[4:0]};
    end

    // Single-channel selection latches the pointer at each mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mono_ch <= '0;
        else if (wr_mode) mono_ch <= ptr_q;
    end

    csr_color_bank #(.NUM_COLORS(NUM_COLORS), .WIDTH(OFS_W), .SEL_W(PTR_W)) u_ofs_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ofs),
        .sel     (ptr_q),
        .wdata   (wdata[OFS_W-1:0]),
        .words   (offset_all),
        .rd_word (ofs_rd)
    );

    csr_color_bank #(.NUM_COLORS(NUM_COLORS), .WIDTH(GAIN_W), .SEL_W(PTR_W)) u_gain_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_gain),
        .sel     (ptr_q),
        .wdata   (wdata[GAIN_W-1:0]),
        .words   (gain_all),
        .rd_word (gain_rd)
    );

    assign clamp_mode = clamp_mode_e'(mode_q[7:6]);
    assign cds_en     = mode_q[0];
    assign mono_en    = mode_q[1];
    assign span_4v    = mode_q[2];
    assign span_2v    = mode_q[3];
    assign span_ext   = mode_q[4];

    csr_clamp_gate u_clamp (
        .mode       (clamp_mode),
        .rst_clk    (samp_rst_clk),
        .line_start (line_start),
        .sw         (clamp_sw)
    );

    // Read multiplexer over the register map; unmapped addresses give zero.
    always_comb begin
        unique case (bus_addr)
            ADR_POINTER: rd_data = {ptr_q, {PTR_LSB{1'b0}}};
            ADR_MODE:    rd_data = mode_q;
            ADR_OFFSET:  rd_data = DATA_W'(ofs_rd);
            ADR_GAIN:    rd_data = {{GAIN_PAD{1'b0}}, gain_rd};
            default:     rd_data = '0;
        endcase
    end

    assign bus_data = rd_drive ? rd_data : 'z;

    assert_mono_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mono_ch));
    assert_line_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_mode == CLAMP_LINE && line_start) |-> !clamp_sw);
    assert_no_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_mode == CLAMP_NONE) |-> !clamp_sw);
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ptr |=> $stable(ptr_q));
endmodule

// File: tb/color_steered_ctrl_regs_tb.sv
module color_steered_ctrl_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_val = '0;
    logic       rclk = 1'b0, lstart = 1'b0;
    wire  [7:0] bus;
    logic       clamp_sw, cds_en, mono_en, span_4v, span_2v, span_ext;
    logic [1:0] mono_ch;
    logic [23:0] offset_all;
    logic [11:0] gain_all;
    int n_checks = 0, n_fail = 0;

    assign bus = tb_oe ? tb_val : 'z;
    always #5 clk = ~clk;

    color_steered_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_rd_n(rd_n),
        .bus_wr_n(wr_n), .bus_addr(addr), .bus_data(bus),
        .samp_rst_clk(rclk), .line_start(lstart), .clamp_sw(clamp_sw),
        .cds_en(cds_en), .mono_en(mono_en), .span_4v(span_4v),
        .span_2v(span_2v), .span_ext(span_ext), .mono_ch(mono_ch),
        .offset_all(offset_all), .gain_all(gain_all)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
        @(negedge clk);
        cs_n = sel_n; addr = a; tb_val = d; tb_oe = 1'b1; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; tb_oe = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #3 d = bus;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(3'd0, d); check("R1 pointer", d, 8'h00);
        bus_read(3'd1, d); check("R1 mode", d, 8'h00);
        check("R1 offsets", offset_all, 24'h0);
        check("R1 gains", gain_all, 12'h0);
        check("R1 mode outs", {cds_en, mono_en, span_4v, span_2v, span_ext, mono_ch}, 7'h0);
    endtask

    task automatic t_steering();
        logic [7:0] d;
        bus_write(3'd0, 8'h40); bus_write(3'd2, 8'h3C);
        check("R4 green only", offset_all, 24'h003C00);
        bus_write(3'd0, 8'h80); bus_write(3'd2, 8'h81);
        bus_write(3'd0, 8'h00); bus_write(3'd2, 8'hFF);
        check("R4 all colors", offset_all, 24'h813CFF);
        bus_read(3'd0, d); check("R3 pointer readback", d, 8'h00);
        bus_write(3'd0, 8'h7F); bus_read(3'd0, d);
        check("R3 low bits read zero", d, 8'h40);
        bus_read(3'd2, d); check("R11 green offset read", d, 8'h3C);
    endtask

    task automatic t_gain();
        logic [7:0] d;
        bus_write(3'd0, 8'h80); bus_write(3'd3, 8'hF7);
        check("R5 blue gain", gain_all, 12'h700);
        bus_read(3'd3, d); check("R5 upper bits zero", d, 8'h07);
        bus_write(3'd0, 8'h00); bus_write(3'd3, 8'h0A);
        check("R5 red gain", gain_all, 12'h70A);
        bus_read(3'd3, d); check("R11 red gain read", d, 8'h0A);
    endtask

    task automatic t_reserved_ptr();
        logic [7:0] d;
        bus_write(3'd0, 8'hC0);
        bus_write(3'd2, 8'h55); bus_write(3'd3, 8'h05);
        check("R6 offsets unchanged", offset_all, 24'h813CFF);
        check("R6 gains unchanged", gain_all, 12'h70A);
        bus_read(3'd2, d); check("R6 offset read zero", d, 8'h00);
        bus_read(3'd3, d); check("R6 gain read zero", d, 8'h00);
    endtask

    task automatic t_unselected();
        logic [7:0] d;
        bus_write(3'd0, 8'h00);
        bus_write(3'd2, 8'h11, 1'b1);
        check("R2 deselected write ignored", offset_all, 24'h813CFF);
        bus_read(3'd2, d); check("R2 red offset kept", d, 8'hFF);
    endtask

    task automatic t_mode();
        logic [7:0] d;
        bus_write(3'd1, 8'h3F);
        check("R7 fields", {span_ext, span_2v, span_4v, mono_en, cds_en}, 5'h1F);
        bus_read(3'd1, d); check("R7 bit5 reads zero", d, 8'h1F);
        bus_write(3'd1, 8'h00);
        check("R7 fields cleared", {span_ext, span_2v, span_4v, mono_en, cds_en}, 5'h00);
    endtask

    task automatic t_clamp();
        bus_write(3'd1, 8'h00);
        @(negedge clk); rclk = 1'b1; lstart = 1'b0; #1 check("R8 line follow", clamp_sw, 1'b1);
        lstart = 1'b1; #1 check("R8 line gated", clamp_sw, 1'b0);
        bus_write(3'd1, 8'h40);
        rclk = 1'b1; lstart = 1'b1; #1 check("R8 pixel high", clamp_sw, 1'b1);
        rclk = 1'b0; #1 check("R8 pixel low", clamp_sw, 1'b0);
        bus_write(3'd1, 8'h80);
        rclk = 1'b1; lstart = 1'b0; #1 check("R8 none", clamp_sw, 1'b0);
        bus_write(3'd1, 8'hC0);
        #1 check("R8 reserved", clamp_sw, 1'b0);
        rclk = 1'b0; lstart = 1'b0;
    endtask

    task automatic t_mono();
        bus_write(3'd0, 8'h80); bus_write(3'd1, 8'h02);
        check("R9 latched blue", mono_ch, 2'd2);
        bus_write(3'd0, 8'h40);
        check("R9 holds after pointer change", mono_ch, 2'd2);
        bus_write(3'd1, 8'h02);
        check("R9 relatched green", mono_ch, 2'd1);
    endtask

    task automatic t_bus();
        logic [7:0] d;
        bus_write(3'd0, 8'h80);
        bus_read(3'd5, d); check("R10 unmapped reads zero", d, 8'h00);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; addr = 3'd0; tb_val = 8'h5A; tb_oe = 1'b1;
        #3 check("R10 no drive without select", bus, 8'h5A);
        @(negedge clk); rd_n = 1'b1; tb_oe = 1'b0;
        bus_read(3'd0, d); check("R10 selected read drives", d, 8'h80);
    endtask

    initial begin
        #500us;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_steering();
        t_gain();
        t_reserved_ptr();
        t_unselected();
        t_mode();
        t_clamp();
        t_mono();
        t_bus();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule